// File: doc/BRIEF.md
# Combining Fetch-and-Add Word Memory

This block is a small array of shared words that two requesters update with atomic fetch-and-add operations. Each requester presents a valid flag, a word address and an increment in a cycle. One cycle later it gets back the value the word held just before its own add was applied. An increment of zero is a plain atomic read.

Both requesters may issue in the same cycle. If they name different words, the two operations run side by side and two words are written. If they name the same word, the block merges them into one update of that word. Requester 0 is placed first in the serial order and requester 1 second. Requester 0 sees the original value k. Requester 1 sees k plus requester 0's increment. The word ends up holding the sum of both increments added to k. Neither requester has to retry, and the outcome cannot be told apart from the two adds running one after the other.

Synchronous reset clears every word to zero. All arithmetic wraps modulo 2^DATA_W.

Top module: `faa_combine_mem`

## Requirements
- R1: While reset is high and in the first cycle after it, both response valid flags are low. Every word reads as zero after reset.
- R2: A request accepted in cycle t produces a response in cycle t+1. That response carries the word's value from before this request's add.
- R3: After a lone request, its word holds the old value plus the increment. A later request to that word returns this value.
- R4: When both requesters are valid with equal addresses in one cycle, requester 0 is ordered first. It receives the old value k. Requester 1 receives k + inc0.
- R5: After such a same-address cycle, the word holds k + inc0 + inc1, written once.
- R6: Requests to different addresses in the same cycle are served independently. Each receives its own word's old value, and both words are updated.
- R7: An increment of zero returns the current value and leaves the word unchanged.
- R8: Additions wrap modulo 2^DATA_W. For example, 16'hFFF0 + 16'h0020 stores 16'h0010.
- R9: rspN_valid in cycle t+1 equals reqN_valid in cycle t. When a requester is idle, its response valid flag is low.
- R10: A request to a word updated by the previous cycle's request sees the updated value, with no bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, clears all words |
| req0_valid | input | 1 | Requester 0 issues an operation |
| req0_addr | input | ADDR_W (4) | Requester 0 word address |
| req0_inc | input | DATA_W (16) | Requester 0 increment (0 = read) |
| req1_valid | input | 1 | Requester 1 issues an operation |
| req1_addr | input | ADDR_W (4) | Requester 1 word address |
| req1_inc | input | DATA_W (16) | Requester 1 increment (0 = read) |
| rsp0_valid | output | 1 | Requester 0 response present |
| rsp0_data | output | DATA_W (16) | Value before requester 0's add |
| rsp1_valid | output | 1 | Requester 1 response present |
| rsp1_data | output | DATA_W (16) | Value before requester 1's add |

## Verification
Two things can happen in the same cycle: an update from both requesters, and a request that lands right after the previous cycle's write to its word. The bench provokes the first with directed same-address and different-address pairs. It also runs a random phase that confines addresses to four words so that collisions are frequent. It provokes the second with back-to-back requests to one word. A behavioural model applies requester 0 and then requester 1 to an integer array each cycle, and every response is compared against it. The final word contents are then read back through zero-increment requests.

// File: rtl/faa_pkg.sv
package faa_pkg;
    parameter int DATA_W = 16;
    parameter int ADDR_W = 4;
    localparam int DEPTH = 1 << ADDR_W;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef struct packed {
        logic  valid;
        addr_t addr;
        word_t inc;
    } req_t;

    typedef struct packed {
        logic  en;
        addr_t addr;
        word_t data;
    } wr_t;

    typedef struct packed {
        logic  valid;
        word_t data;
    } rsp_t;

    function automatic word_t wrap_add(input word_t a, input word_t b);
        return word_t'(a + b);
    endfunction
endpackage

// File: rtl/faa_word_array.sv
module faa_word_array
    import faa_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  addr_t rd_a_addr,
    input  addr_t rd_b_addr,
    output word_t rd_a_data,
    output word_t rd_b_data,
    input  wr_t   wr_a,
    input  wr_t   wr_b
);
    word_t mem [DEPTH];

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_word
            always_ff @(posedge clk) begin
                if (rst)
                    mem[g] <= '0;
                else if (wr_a.en && wr_a.addr == addr_t'(g))
                    mem[g] <= wr_a.data;
                else if (wr_b.en && wr_b.addr == addr_t'(g))
                    mem[g] <= wr_b.data;
            end
        end
    endgenerate

    assign rd_a_data = mem[rd_a_addr];
    assign rd_b_data = mem[rd_b_addr];
endmodule

// File: rtl/faa_combiner.sv
module faa_combiner
    import faa_pkg::*;
(
    input  req_t  req0,
    input  req_t  req1,
    input  word_t cur0,
    input  word_t cur1,
    output word_t old0,
    output word_t old1,
    output wr_t   wr_a,
    output wr_t   wr_b
);
    logic  merged;
    word_t after0;

    always_comb begin
        merged = req0.valid && req1.valid && (req0.addr == req1.addr);
        after0 = wrap_add(cur0, req0.inc);

        old0 = cur0;
        old1 = merged ? after0 : cur1;

        wr_a.en   = req0.valid;
        wr_a.addr = req0.addr;
        wr_a.data = merged ? wrap_add(after0, req1.inc) : after0;

        wr_b.en   = req1.valid && !merged;
        wr_b.addr = req1.addr;
        wr_b.data = wrap_add(cur1, req1.inc);
    end
endmodule

// File: rtl/faa_resp_reg.sv
module faa_resp_reg
    import faa_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  valid_in,
    input  word_t data_in,
    output rsp_t  rsp
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp <= '0;
        end else begin
            rsp.valid <= valid_in;
            if (valid_in)
                rsp.data <= data_in;
        end
    end
endmodule

// File: rtl/faa_combine_mem.sv
module faa_combine_mem
    import faa_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req0_valid,
    input  logic [ADDR_W-1:0] req0_addr,
    input  logic [DATA_W-1:0] req0_inc,
    input  logic              req1_valid,
    input  logic [ADDR_W-1:0] req1_addr,
    input  logic [DATA_W-1:0] req1_inc,
    output logic              rsp0_valid,
    output logic [DATA_W-1:0] rsp0_data,
    output logic              rsp1_valid,
    output logic [DATA_W-1:0] rsp1_data
);
    req_t  req0, req1;
    word_t cur0, cur1, old0, old1;
    wr_t   wr_a, wr_b;
    rsp_t  rsp0, rsp1;

    assign req0 = '{valid: req0_valid, addr: req0_addr, inc: req0_inc};
    assign req1 = '{valid: req1_valid, addr: req1_addr, inc: req1_inc};

    faa_word_array u_array (
        .clk(clk), .rst(rst),
        .rd_a_addr(req0.addr), .rd_b_addr(req1.addr),
        .rd_a_data(cur0), .rd_b_data(cur1),
        .wr_a(wr_a), .wr_b(wr_b)
    );

    faa_combiner u_comb (
        .req0(req0), .req1(req1), .cur0(cur0), .cur1(cur1),
        .old0(old0), .old1(old1), .wr_a(wr_a), .wr_b(wr_b)
    );

    faa_resp_reg u_rsp0 (
        .clk(clk), .rst(rst), .valid_in(req0.valid), .data_in(old0), .rsp(rsp0)
    );

    faa_resp_reg u_rsp1 (
        .clk(clk), .rst(rst), .valid_in(req1.valid), .data_in(old1), .rsp(rsp1)
    );

    assign rsp0_valid = rsp0.valid;
    assign rsp0_data  = rsp0.data;
    assign rsp1_valid = rsp1.valid;
    assign rsp1_data  = rsp1.data;
endmodule

// File: rtl/faa_combine_mem_chk.sv
module faa_combine_mem_chk
    import faa_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        req0_valid,
    input addr_t       req0_addr,
    input word_t       req0_inc,
    input logic        req1_valid,
    input addr_t       req1_addr,
    input word_t       req1_inc,
    input logic        rsp0_valid,
    input word_t       rsp0_data,
    input logic        rsp1_valid,
    input word_t       rsp1_data
);
    logic [1:0] live;
    always_ff @(posedge clk) begin
        if (rst) live <= '0;
        else if (live != 2'd3) live <= live + 2'd1;
    end

    // R9
    p_valid_follow0_r9: assert property (@(posedge clk) disable iff (rst)
        req0_valid |=> rsp0_valid);
    p_valid_follow1_r9: assert property (@(posedge clk) disable iff (rst)
        req1_valid |=> rsp1_valid);
    p_idle0_r9: assert property (@(posedge clk) disable iff (rst)
        !req0_valid |=> !rsp0_valid);
    p_idle1_r9: assert property (@(posedge clk) disable iff (rst)
        !req1_valid |=> !rsp1_valid);

    // R1
    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> (!rsp0_valid && !rsp1_valid));

    // R4
    p_merge_order_r4: assert property (@(posedge clk) disable iff (rst)
        (req0_valid && req1_valid && req0_addr == req1_addr)
        |=> rsp1_data == word_t'(rsp0_data + $past(req0_inc)));

    // R10
    p_back_to_back_r10: assert property (@(posedge clk) disable iff (rst)
        (live == 2'd3 && req0_valid && !req1_valid && $past(req0_valid)
         && !$past(req1_valid) && req0_addr == $past(req0_addr))
        |=> rsp0_data == word_t'($past(rsp0_data) + $past(req0_inc, 2)));

    // R7
    p_zero_read_r7: assert property (@(posedge clk) disable iff (rst)
        (live == 2'd3 && req0_valid && !req1_valid && $past(req0_valid)
         && !$past(req1_valid) && req0_addr == $past(req0_addr)
         && $past(req0_inc) == '0)
        |=> rsp0_data == $past(rsp0_data));
endmodule

bind faa_combine_mem faa_combine_mem_chk u_chk (
    .clk(clk), .rst(rst),
    .req0_valid(req0_valid), .req0_addr(req0_addr), .req0_inc(req0_inc),
    .req1_valid(req1_valid), .req1_addr(req1_addr), .req1_inc(req1_inc),
    .rsp0_valid(rsp0_valid), .rsp0_data(rsp0_data),
    .rsp1_valid(rsp1_valid), .rsp1_data(rsp1_data)
);

// File: tb/faa_combine_mem_bench.sv
`timescale 1ns/1ps
module faa_combine_mem_bench;
    import faa_pkg::*;

    logic clk = 0;
    logic rst = 1;
    logic req0_valid = 0, req1_valid = 0;
    addr_t req0_addr = '0, req1_addr = '0;
    word_t req0_inc = '0, req1_inc = '0;
    logic rsp0_valid, rsp1_valid;
    word_t rsp0_data, rsp1_data;

    int errors = 0;
    int checks = 0;
    word_t model [DEPTH];

    always #2 clk = ~clk;

    faa_combine_mem u_faa_combine_mem (
        .clk(clk), .rst(rst),
        .req0_valid(req0_valid), .req0_addr(req0_addr), .req0_inc(req0_inc),
        .req1_valid(req1_valid), .req1_addr(req1_addr), .req1_inc(req1_inc),
        .rsp0_valid(rsp0_valid), .rsp0_data(rsp0_data),
        .rsp1_valid(rsp1_valid), .rsp1_data(rsp1_data)
    );

    task automatic check(input logic ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One request cycle: model applies requester 0 then requester 1 in series
    task automatic step(input logic v0, input addr_t a0, input word_t i0,
                        input logic v1, input addr_t a1, input word_t i1,
                        input string tag);
        word_t e0, e1;
        e0 = '0; e1 = '0;
        @(negedge clk);
        req0_valid = v0; req0_addr = a0; req0_inc = i0;
        req1_valid = v1; req1_addr = a1; req1_inc = i1;
        if (v0) begin e0 = model[a0]; model[a0] = word_t'(model[a0] + i0); end
        if (v1) begin e1 = model[a1]; model[a1] = word_t'(model[a1] + i1); end
        @(posedge clk); #1;
        check(rsp0_valid == v0, {tag, " R9 rsp0_valid"}, rsp0_valid, v0);
        check(rsp1_valid == v1, {tag, " R9 rsp1_valid"}, rsp1_valid, v1);
        if (v0) check(rsp0_data == e0, {tag, " rsp0_data"}, rsp0_data, e0);
        if (v1) check(rsp1_data == e1, {tag, " rsp1_data"}, rsp1_data, e1);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int k = 0; k < DEPTH; k++) model[k] = '0;
        repeat (3) @(posedge clk);
        #1;
        check(!rsp0_valid && !rsp1_valid, "R1 valid low in reset", {rsp0_valid, rsp1_valid}, 0);
        @(negedge clk); rst = 0;
        @(posedge clk); #1;
        check(!rsp0_valid && !rsp1_valid, "R1 valid low after reset", {rsp0_valid, rsp1_valid}, 0);

        // R1 / R7: all words read zero
        for (int k = 0; k < DEPTH; k += 2)
            step(1, addr_t'(k), 0, 1, addr_t'(k + 1), 0, "R1 zero after reset");

        step(1, 4'd3, 16'd5, 0, 0, 0, "R2 lone add");
        step(0, 0, 0, 1, 4'd3, 16'd0, "R3 updated word");
        step(0, 0, 0, 0, 0, 0, "R9 idle");
        step(1, 4'd7, 16'd10, 1, 4'd7, 16'd3, "R4 same addr order");
        step(1, 4'd7, 16'd0, 0, 0, 0, "R5 merged sum");
        step(1, 4'd1, 16'd100, 1, 4'd2, 16'd200, "R6 split");
        step(1, 4'd2, 16'd0, 1, 4'd1, 16'd0, "R6 both updated");
        step(1, 4'd7, 16'd0, 1, 4'd7, 16'd0, "R7 zero read pair");
        step(1, 4'd7, 16'd0, 0, 0, 0, "R7 unchanged");
        step(1, 4'd9, 16'hFFF0, 0, 0, 0, "R8 preload");
        step(0, 0, 0, 1, 4'd9, 16'h0020, "R8 wrap add");
        step(1, 4'd9, 16'd0, 0, 0, 0, "R8 wrapped value");
        step(1, 4'd5, 16'hFFFF, 1, 4'd5, 16'h0002, "R8 R5 merged wrap");
        step(1, 4'd5, 16'd1, 0, 0, 0, "R10 chain a");
        step(1, 4'd5, 16'd1, 0, 0, 0, "R10 chain b");
        step(0, 0, 0, 1, 4'd5, 16'd1, "R10 chain c");
        step(1, 4'd5, 16'd4, 1, 4'd5, 16'd4, "R10 chain merged");

        for (int n = 0; n < 300; n++)
            step(logic'($urandom_range(0, 1)), addr_t'($urandom_range(0, 3)), word_t'($urandom),
                 logic'($urandom_range(0, 1)), addr_t'($urandom_range(0, 3)), word_t'($urandom),
                 "R4 R6 random");

        for (int k = 0; k < DEPTH; k += 2)
            step(1, addr_t'(k), 0, 1, addr_t'(k + 1), 0, "R3 R5 final contents");

        step(0, 0, 0, 0, 0, 0, "R9 final idle");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule